// File: doc/BRIEF.md
# I2C Configuration Register Target with Byte and Block Transfers

This block is an I2C target that holds a small bank of 8-bit configuration registers for the rest of the chip. A controller on the two-wire bus writes and reads the bank one register at a time or as a run of consecutive registers. The first byte after a write address is a command byte. Its top bit picks byte mode or block mode, and its low bits give the register offset where the transfer starts. Every data byte the target receives lands in its register as soon as the byte's eighth bit is clocked in. The whole bank is driven out on a flat output vector, so downstream logic sees each change at once.

One control bit starts a copy of the bank into a backing store. That store is modelled as a fixed-latency snapshot. While the copy runs, a status bit reads as 1 and writes have no effect, but reads are served normally. SCL and SDA are sampled with the system clock and must be slow relative to it. The bus has no valid/ready flow control and the target never stretches the clock, so the controller alone sets the pace. The register outputs and the SDA pins are plain level signals.

Top module: `i2ct_cfg_top`

## Requirements
- R1: The target responds only to the 7-bit address 1100101, with the following bit giving the direction (1 read, 0 write). It ACKs a matching address. For any other address it leaves SDA released and the registers unchanged.
- R2: A command byte with bit 7 set selects byte mode, and its bits 6:0 taken modulo NUM_REGS give the offset. A byte-mode write updates only that register. Any further data bytes in the same transaction are ACKed and have no effect.
- R3: A byte-mode read (write address, command, repeated START, read address) returns the selected register. Every later byte in that read returns 8'hFF.
- R4: A command byte with bit 7 clear selects block mode. Block writes fill consecutive registers upward from the offset, wrapping modulo NUM_REGS. A STOP after any byte keeps every byte already received.
- R5: Each received data byte is visible on `regs_o` before its ACK clock pulse, in both modes.
- R6: A block read returns N bytes upward from the offset, most-significant bit first, with the same wrap. N is the count held in bits 4:0 of register 02h. Bytes beyond N read 8'hFF, and a count of 0 yields only 8'hFF.
- R7: The target ACKs every byte written to it. It changes SDA only while SCL is low. On a read, a controller NACK or a STOP makes it release SDA.
- R8: Writing a 1 to bit 0 of register 06h starts a copy. Bit 6 of register 01h then reads 1 for COPY_CYCLES clock cycles. At the end the trigger bit clears and `nv_image_o` holds the bank, with these two status bits stored as 0. Bit 6 of register 01h cannot be written.
- R9: Data bytes written while the copy is in progress are ACKed and ignored.
- R10: Byte and block reads return correct register values while the copy is in progress.
- R11: After reset every register is 0 except register 02h, which holds NUM_REGS. `nv_image_o` is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Data value driven when enabled, constant 0 |
| sda_oe | output | 1 | Pulls SDA low when 1 (open drain) |
| regs_o | output | NUM_REGS*8 | Register bank, register i at bits 8i+7:8i, status bit included |
| nv_image_o | output | NUM_REGS*8 | Backing-store contents after the last completed copy |

## Verification
The bench builds the block with NUM_REGS = 8 and COPY_CYCLES = 8000. The small bank lets it sweep every offset in both modes, including command offsets above the bank size, every block-write length with wrap-around, and every byte count from 0 to 8 on block reads. With the longer copy window, a trigger, an ignored block write, a byte read and a block read all fit inside one copy. The bench can then check that the status bit stays high, that writes are dropped and that reads are still served, before it checks the snapshot and the self-clearing trigger.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_st_e;

  localparam int REG_STATUS = 1;
  localparam int REG_COUNT  = 2;
  localparam int REG_CTRL   = 6;
  localparam int BUSY_BIT   = 6;
  localparam int TRIG_BIT   = 0;
  localparam int CNT_W      = 5;
  localparam int RDCNT_W    = CNT_W + 1;

endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_meta, sda_meta;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_meta <= 2'b11;
      sda_meta <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_meta <= {scl_meta[0], scl_i};
      sda_meta <= {sda_meta[0], sda_i};
      scl_q    <= scl_meta[1];
      sda_q    <= sda_meta[1];
    end
  end

  assign scl_s     = scl_meta[1];
  assign sda_s     = sda_meta[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2ct_bus_fsm.sv
module i2ct_bus_fsm
  import i2ct_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1100101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       rx_is_cmd,
  output logic       rd_begin,
  output logic       tx_take,
  output logic       sda_oe
);
  bus_st_e    st;
  logic [3:0] bitcnt;
  logic [7:0] sr;
  logic [6:0] tx_sr;
  logic       rw, expect_cmd, mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bitcnt     <= '0;
      sr         <= '0;
      tx_sr      <= '1;
      rw         <= 1'b0;
      expect_cmd <= 1'b0;
      mack       <= 1'b0;
      sda_oe     <= 1'b0;
      rx_valid   <= 1'b0;
      rx_byte    <= '0;
      rx_is_cmd  <= 1'b0;
      rd_begin   <= 1'b0;
      tx_take    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rd_begin <= 1'b0;
      tx_take  <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sr     <= {sr[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (st == ST_RX) begin
                rx_valid   <= 1'b1;
                rx_byte    <= sr;
                rx_is_cmd  <= expect_cmd;
                expect_cmd <= 1'b0;
                sda_oe     <= 1'b1;
                st         <= ST_RX_ACK;
              end else if (sr[7:1] == DEV_ADDR) begin
                rw       <= sr[0];
                rd_begin <= sr[0];
                if (!sr[0]) expect_cmd <= 1'b1;
                sda_oe   <= 1'b1;
                st       <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                tx_sr   <= tx_byte[6:0];
                sda_oe  <= ~tx_byte[7];
                tx_take <= 1'b1;
                st      <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                sda_oe <= ~tx_sr[6];
                tx_sr  <= {tx_sr[5:0], 1'b1};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack) begin
                tx_sr   <= tx_byte[6:0];
                sda_oe  <= ~tx_byte[7];
                tx_take <= 1'b1;
                st      <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: a STOP always leaves the line released
  assert_release_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R7: the target starts pulling SDA low only while SCL is low
  assert_pull_while_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R5: one write strobe per received byte
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/i2ct_reg_bank.sv
module i2ct_reg_bank
  import i2ct_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  input  logic                  rx_is_cmd,
  input  logic                  rd_begin,
  input  logic                  tx_take,
  input  logic                  busy,
  input  logic                  copy_done,
  output logic [7:0]            tx_byte,
  output logic                  copy_start,
  output logic [NUM_REGS*8-1:0] view_flat,
  output logic [NUM_REGS*8-1:0] store_flat
);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic [7:0]         mem [NUM_REGS];
  logic [PTR_W-1:0]   ptr, rd_ptr;
  logic               byte_mode, wr_used;
  logic [RDCNT_W-1:0] rd_cnt;
  logic               wr_fire, rd_ok;
  logic [CNT_W-1:0]   bcnt;

  assign wr_fire    = rx_valid && !rx_is_cmd && !busy && (!byte_mode || !wr_used);
  assign copy_start = wr_fire && (ptr == PTR_W'(REG_CTRL)) && rx_byte[TRIG_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_VAL = (i == REG_COUNT) ? 8'(NUM_REGS) : 8'h00;
    localparam logic [7:0] WR_MASK = (i == REG_STATUS) ? ~(8'h01 << BUSY_BIT) : 8'hFF;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= RST_VAL;
      end else if (wr_fire && ptr == PTR_W'(i)) begin
        mem[i] <= rx_byte & WR_MASK;
      end else if (i == REG_CTRL && copy_done) begin
        mem[i][TRIG_BIT] <= 1'b0;
      end
    end
    if (i == REG_STATUS) begin : g_stat
      assign view_flat[i*8 +: 8]  = mem[i] | (8'(busy) << BUSY_BIT);
      assign store_flat[i*8 +: 8] = mem[i];
    end else if (i == REG_CTRL) begin : g_ctrl
      assign view_flat[i*8 +: 8]  = mem[i];
      assign store_flat[i*8 +: 8] = mem[i] & ~(8'h01 << TRIG_BIT);
    end else begin : g_plain
      assign view_flat[i*8 +: 8]  = mem[i];
      assign store_flat[i*8 +: 8] = mem[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      byte_mode <= 1'b0;
      wr_used   <= 1'b0;
      rd_ptr    <= '0;
      rd_cnt    <= '0;
    end else begin
      if (rx_valid && rx_is_cmd) begin
        ptr       <= PTR_W'(rx_byte[6:0] % 7'(NUM_REGS));
        byte_mode <= rx_byte[7];
        wr_used   <= 1'b0;
      end else if (rx_valid) begin
        wr_used <= 1'b1;
        if (!byte_mode) ptr <= ptr + 1'b1;
      end
      if (rd_begin) begin
        rd_ptr <= ptr;
        rd_cnt <= '0;
      end else if (tx_take) begin
        if (!byte_mode) rd_ptr <= rd_ptr + 1'b1;
        if (rd_cnt != '1) rd_cnt <= rd_cnt + 1'b1;
      end
    end
  end

  assign bcnt    = mem[REG_COUNT][CNT_W-1:0];
  assign rd_ok   = byte_mode ? (rd_cnt == '0) : (rd_cnt < {1'b0, bcnt});
  assign tx_byte = rd_ok ? view_flat[rd_ptr*8 +: 8] : 8'hFF;

  // R9: no stored value moves while a copy is running
  assert_busy_blocks_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(store_flat));

  // R8: a copy never starts while one is running
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !copy_start);

endmodule

// File: rtl/i2ct_nv_copy.sv
module i2ct_nv_copy #(
  parameter int NUM_REGS    = 16,
  parameter int COPY_CYCLES = 50000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NUM_REGS*8-1:0] image_in,
  output logic                  busy,
  output logic                  done,
  output logic [NUM_REGS*8-1:0] nv_out
);
  localparam int CW = $clog2(COPY_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      nv_out <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          nv_out <= image_in;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(COPY_CYCLES - 1);
      end
    end
  end

  // R8: a trigger always opens the busy window
  assert_start_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R8: completion closes the busy window
  assert_done_clears_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/i2ct_cfg_top.sv
module i2ct_cfg_top #(
  parameter int         NUM_REGS    = 16,
  parameter int         COPY_CYCLES = 50000,
  parameter logic [6:0] DEV_ADDR    = 7'b1100101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_o,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [NUM_REGS*8-1:0] nv_image_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic rx_valid, rx_is_cmd, rd_begin, tx_take;
  logic [7:0] rx_byte, tx_byte;
  logic busy, copy_done, copy_start;
  logic [NUM_REGS*8-1:0] store_flat;

  assign sda_o = 1'b0;

  i2ct_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_is_cmd(rx_is_cmd),
    .rd_begin(rd_begin), .tx_take(tx_take), .sda_oe(sda_oe)
  );

  i2ct_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_is_cmd(rx_is_cmd), .rd_begin(rd_begin), .tx_take(tx_take),
    .busy(busy), .copy_done(copy_done), .tx_byte(tx_byte),
    .copy_start(copy_start), .view_flat(regs_o), .store_flat(store_flat)
  );

  i2ct_nv_copy #(.NUM_REGS(NUM_REGS), .COPY_CYCLES(COPY_CYCLES)) u_copy (
    .clk(clk), .rst_n(rst_n), .start(copy_start), .image_in(store_flat),
    .busy(busy), .done(copy_done), .nv_out(nv_image_o)
  );

endmodule

// File: tb/i2ct_cfg_top_tb.sv
module i2ct_cfg_top_tb;
  localparam int NR = 8;
  localparam int CC = 8000;
  localparam int Q  = 8;
  localparam logic [6:0] ADDR = 7'b1100101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_o, sda_oe;
  logic [NR*8-1:0] regs_o, nv_image_o, regs_mid;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~(sda_oe & ~sda_o);

  i2ct_cfg_top #(.NUM_REGS(NR), .COPY_CYCLES(CC), .DEV_ADDR(ADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .regs_o(regs_o), .nv_image_o(nv_image_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] model [NR];
  bit busy_exp = 0;

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] view(int i);
    logic [7:0] v = model[i];
    if (i == 1) v[6] = busy_exp;
    return v;
  endfunction

  function automatic logic [NR*8-1:0] exp_flat();
    logic [NR*8-1:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = view(i);
    return f;
  endfunction

  function automatic logic [7:0] gen(int idx, int s);
    logic [7:0] v = 8'(s * 37 + idx * 11 + 5);
    if (idx == 6) v[0] = 1'b0;
    if (idx == 2) v[4:0] = 5'(s % 9);
    return v;
  endfunction

  task automatic apply(int idx, logic [7:0] d);
    if (busy_exp) return;
    if (idx == 1) d[6] = 1'b0;
    model[idx] = d;
    if (idx == 6 && d[0]) busy_exp = 1;
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; qw(); scl_m = 1; qw(); sda_m = 0; qw(); scl_m = 0; qw();
  endtask

  task automatic i2c_stop();
    sda_m = 0; qw(); scl_m = 1; qw(); sda_m = 1; qw();
  endtask

  task automatic put_bit(bit b);
    sda_m = b; qw(); scl_m = 1; qw(); qw(); scl_m = 0; qw();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1; qw(); scl_m = 1; qw(); b = sda_line; qw(); scl_m = 0; qw();
  endtask

  task automatic send_byte(logic [7:0] v, output bit ack);
    bit l;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    regs_mid = regs_o;
    get_bit(l);
    ack = !l;
  endtask

  task automatic recv_byte(bit nack, output logic [7:0] v);
    bit l;
    for (int i = 7; i >= 0; i--) begin get_bit(l); v[i] = l; end
    put_bit(nack);
  endtask

  task automatic wr_txn(bit bm, int cmdoff, int n, int seed, string req);
    bit ack;
    int base = cmdoff % NR;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    check(ack, "R1 address ack", 128'(ack), 128'(1));
    send_byte({bm, 7'(cmdoff)}, ack);
    check(ack, "R7 command ack", 128'(ack), 128'(1));
    for (int k = 0; k < n; k++) begin
      int idx = bm ? base : (base + k) % NR;
      logic [7:0] d = gen(idx, seed + k);
      send_byte(d, ack);
      if (!bm || k == 0) apply(idx, d);
      check(ack, "R7 data ack", 128'(ack), 128'(1));
      check(regs_mid == exp_flat(), "R5 immediate update", 128'(regs_mid), 128'(exp_flat()));
    end
    i2c_stop();
    check(regs_o == exp_flat(), req, 128'(regs_o), 128'(exp_flat()));
  endtask

  task automatic rd_txn(bit bm, int cmdoff, int n, string req);
    bit ack;
    int base = cmdoff % NR;
    int cnt = int'(model[2][4:0]);
    logic [7:0] got, exp;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte({bm, 7'(cmdoff)}, ack);
    i2c_start();
    send_byte({ADDR, 1'b1}, ack);
    check(ack, "R1 read address ack", 128'(ack), 128'(1));
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, got);
      if (bm) exp = (k == 0) ? view(base) : 8'hFF;
      else    exp = (k < cnt) ? view((base + k) % NR) : 8'hFF;
      check(got == exp, req, 128'(got), 128'(exp));
    end
    check(sda_oe == 1'b0, "R7 released after NACK", 128'(sda_oe), 128'(0));
    i2c_stop();
    check(sda_oe == 1'b0, "R7 released after STOP", 128'(sda_oe), 128'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    for (int i = 0; i < NR; i++) model[i] = (i == 2) ? 8'(NR) : 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: reset state
    check(regs_o == exp_flat(), "R11 reset registers", 128'(regs_o), 128'(exp_flat()));
    check(nv_image_o == '0, "R11 reset image", 128'(nv_image_o), 128'(0));
    check(sda_oe == 1'b0, "R11 released", 128'(sda_oe), 128'(0));

    // R1: foreign address is not acknowledged and changes nothing
    i2c_start();
    send_byte({7'b1100100, 1'b0}, ack);
    check(!ack, "R1 foreign address", 128'(ack), 128'(0));
    send_byte(8'h80, ack);
    send_byte(8'h5A, ack);
    i2c_stop();
    check(regs_o == exp_flat(), "R1 no change", 128'(regs_o), 128'(exp_flat()));

    // R2 / R3: byte mode at every offset, with offsets above the bank size
    for (int o = 0; o < NR; o++) begin
      int co = o + NR * (o % 3);
      wr_txn(1'b1, co, 2, o * 5 + 1, "R2 byte write");
    end
    for (int o = 0; o < NR; o++) begin
      int co = o + NR * ((o + 1) % 3);
      rd_txn(1'b1, co, 2, "R3 byte read");
    end

    // R4: block writes from every offset, assorted lengths with wrap
    for (int s = 0; s < NR; s++)
      wr_txn(1'b0, s, 1 + (s * 3) % NR, s * 7 + 3, "R4 block write");

    // R6: block reads for every count 0..NR
    for (int c = 0; c <= NR; c++) begin
      wr_txn(1'b1, 2, 1, c, "R2 set byte count");
      check(int'(model[2][4:0]) == c, "R6 count setup", 128'(model[2]), 128'(c));
      rd_txn(1'b0, c % NR, c + 2, "R6 block read");
    end

    // R8 / R9 / R10: copy in progress
    wr_txn(1'b1, 2, 1, 3, "R2 count for copy test");
    i2c_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte({1'b1, 7'd6}, ack);
    send_byte(8'h81, ack);
    apply(6, 8'h81);
    check(regs_mid == exp_flat(), "R8 trigger and busy", 128'(regs_mid), 128'(exp_flat()));
    i2c_stop();
    check(regs_o[8 + 6] == 1'b1, "R8 busy bit set", 128'(regs_o[14]), 128'(1));
    wr_txn(1'b0, 0, 3, 99, "R9 writes ignored while busy");
    wr_txn(1'b1, 1, 1, 50, "R9 status write ignored while busy");
    rd_txn(1'b1, 1, 1, "R10 byte read while busy");
    rd_txn(1'b0, 5, 4, "R10 block read while busy");
    check(regs_o[8 + 6] == 1'b1, "R8 still busy", 128'(regs_o[14]), 128'(1));
    repeat (CC) @(negedge clk);
    busy_exp = 0;
    model[6][0] = 1'b0;
    check(regs_o == exp_flat(), "R8 trigger and busy cleared", 128'(regs_o), 128'(exp_flat()));
    check(nv_image_o == exp_flat(), "R8 stored image", 128'(nv_image_o), 128'(exp_flat()));

    // R8: status bit cannot be written once idle
    wr_txn(1'b1, 1, 1, 40, "R8 status bit not writable");
    check(regs_o[14] == 1'b0, "R8 status bit reads idle", 128'(regs_o[14]), 128'(0));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule